// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked on-chip request port to an external 32768 x 8 asynchronous static RAM. The RAM has a 15-bit address, an 8-bit shared data bus and three active-low strobes: chip select, output enable and write enable. A request carries an address, a direction and, for a write, one data byte. The controller turns it into a strobe sequence whose every interval is a whole number of clock cycles. Each interval is rounded up from a nanosecond limit by a parameterised clock period. A second timing set for low-supply operation is picked by a parameter.

A read is returned on `rdata_o` together with a one-cycle `done_o`. A write also ends with `done_o`. `ready_o` stays low from acceptance until the cycle and a recovery gap have finished, so the RAM's drivers are off before the next access starts. The bus is modelled as a separate output value, output enable and input value. The controller drives it only inside the write pulse, after the RAM's outputs have had time to turn off. When `lowpwr_i` is high, the idle RAM is left deselected. Otherwise it stays selected with its outputs disabled.

With the default parameters (10 ns clock, fast 5 V timing), a read lasts 7 cycles, a write lasts 7 cycles, the write driver turn-on waits 3 cycles and the recovery gap is 3 cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: During a read, `ram_ce_no`=0, `ram_oe_no`=0 and `ram_we_no`=1 from the accepting edge until RD_CYC edges later (7 by default). At that edge chip select returns to its idle level and output enable goes high. Write enable is never low while chip select and output enable are both low.
- R2: The byte on `ram_dq_i` at the last edge of a read is registered into `rdata_o`. `done_o` is high for exactly one cycle, starting RD_CYC edges after acceptance for a read and WR_CYC edges after acceptance for a write.
- R3: During a write, `ram_ce_no`=0 and `ram_we_no`=0 for exactly WR_CYC cycles (7 by default), and this interval is never shorter than WP_CYC (6). `ram_oe_no` stays 1 for the whole write.
- R4: `ram_dq_oe_o` rises WOD_CYC edges (3 by default) after write enable falls and drops on the same edge that write enable rises. It is never 1 unless both chip select and write enable are low.
- R5: While `ram_dq_oe_o` is 1, `ram_dq_o` equals the byte of the accepted write request. The driver is on for at least DS_CYC cycles (4) before write enable rises.
- R6: `ready_o` is 0 from the accepting edge until REC_CYC edges (3) after the edge that ends the cycle. A request presented while `ready_o` is 0 is ignored and starts no cycle.
- R7: In idle, `ram_oe_no`=1 and `ram_we_no`=1. `ram_ce_no` follows `lowpwr_i`: 1 (deselected) when it is high and 0 when it is low. This level is applied on the next edge.
- R8: `ram_addr_o` holds the accepted request's address, unchanged, for the whole cycle, whatever `addr_i` does after acceptance.
- R9: After reset, all three strobes are 1, `ram_dq_oe_o`=0, `done_o`=0 and `ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; accepted on an edge where ready_o is 1 |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Request word address |
| wdata_i | input | 8 | Write byte |
| lowpwr_i | input | 1 | Keep the RAM deselected while idle |
| ready_o | output | 1 | Controller can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| ram_addr_o | output | 15 | RAM address |
| ram_ce_no | output | 1 | RAM chip select, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write enable, active low |
| ram_dq_o | output | 8 | Byte driven onto the shared bus |
| ram_dq_oe_o | output | 1 | Enables the controller's bus driver |
| ram_dq_i | input | 8 | Byte seen on the shared bus |

## Verification
The assertions assume that requesters only count on acceptance while `ready_o` is high, and that `rst_ni` is applied before the first request. The stimulus always raises `req_i` one cycle at a time on a cycle where `ready_o` was sampled high. It also drops `req_i` after one cycle, except for deliberate requests made while the controller is busy. The bench RAM model returns the inverted byte until the strobes and the address have been steady for the read length. It keeps driving for a turn-off tail after its outputs are disabled, so that early sampling and driver overlap both become visible at the ports.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RECOVER
  } ctrl_state_e;

  // nanoseconds -> clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ps);
    return (t_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] elapsed_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = cnt_q;

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WR_CYC  = 7,
  parameter int unsigned WP_CYC  = 6,
  parameter int unsigned WOD_CYC = 3,
  parameter int unsigned REC_CYC = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             lowpwr_i,
  input  logic [CNT_W-1:0] elapsed_i,
  output logic             tmr_clr_o,
  output logic             accept_o,
  output logic             rd_sample_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             drv_o
);

  ctrl_state_e state_q, state_d;
  logic ce_n_q, oe_n_q, we_n_q, drv_q, done_q;
  logic ce_n_d, oe_n_d, we_n_d, drv_d, done_d;
  logic rd_last, wr_drv_on, wr_last, rec_last;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = req_i && ready_o;
  assign rd_last   = (state_q == ST_READ)    && (elapsed_i == CNT_W'(RD_CYC - 1));
  assign wr_drv_on = (state_q == ST_WRITE)   && (elapsed_i == CNT_W'(WOD_CYC - 1));
  assign wr_last   = (state_q == ST_WRITE)   && (elapsed_i == CNT_W'(WR_CYC - 1));
  assign rec_last  = (state_q == ST_RECOVER) && (elapsed_i == CNT_W'(REC_CYC - 1));

  always_comb begin
    state_d   = state_q;
    ce_n_d    = ce_n_q;
    oe_n_d    = oe_n_q;
    we_n_d    = we_n_q;
    drv_d     = drv_q;
    done_d    = 1'b0;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ce_n_d = lowpwr_i;
        oe_n_d = 1'b1;
        we_n_d = 1'b1;
        if (accept_o) begin
          tmr_clr_o = 1'b1;
          ce_n_d    = 1'b0;
          if (wr_i) begin
            state_d = ST_WRITE;
            we_n_d  = 1'b0;
          end else begin
            state_d = ST_READ;
            oe_n_d  = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (rd_last) begin
          done_d    = 1'b1;
          ce_n_d    = lowpwr_i;
          oe_n_d    = 1'b1;
          tmr_clr_o = 1'b1;
          state_d   = ST_RECOVER;
        end
      end
      ST_WRITE: begin
        if (wr_drv_on) drv_d = 1'b1;
        if (wr_last) begin
          // driver released on the same edge write enable rises
          we_n_d    = 1'b1;
          drv_d     = 1'b0;
          done_d    = 1'b1;
          ce_n_d    = lowpwr_i;
          tmr_clr_o = 1'b1;
          state_d   = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        ce_n_d = lowpwr_i;
        if (rec_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drv_q   <= drv_d;
      done_q  <= done_d;
    end
  end

  assign rd_sample_o = rd_last;
  assign done_o      = done_q;
  assign ce_n_o      = ce_n_q;
  assign oe_n_o      = oe_n_q;
  assign we_n_o      = we_n_q;
  assign drv_o       = drv_q;

  // checker: length of the current write-enable low interval
  logic [CNT_W-1:0] wp_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wp_cnt_q <= '0;
    else if (!we_n_q && !ce_n_q)     wp_cnt_q <= wp_cnt_q + 1'b1;
    else                             wp_cnt_q <= '0;
  end

  assert_rd_we_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_q && !oe_n_q) |-> we_n_q);

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_wr_oe_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> (oe_n_q && !ce_n_q));

  assert_wp_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> (wp_cnt_q >= CNT_W'(WP_CYC)));

  assert_drv_in_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> (!we_n_q && !ce_n_q));

  assert_drv_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_q) |-> !drv_q);

  assert_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_q || !oe_n_q || done_q) |-> !ready_o);

  assert_lowpwr_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ready_o && lowpwr_i && !req_i) |-> ce_n_q);

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              rd_sample_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_q <= '0;
    else if (rd_sample_i) rdata_q <= ram_dq_i;
  end

  assign ram_addr_o = addr_q;
  assign ram_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;

  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(addr_q));

  assert_wdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(wdata_q));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter bit          LOW_VOLTAGE   = 1'b0,
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lowpwr_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  // timing set, nanoseconds
  localparam int unsigned T_RC_NS  = LOW_VOLTAGE ? 200 : 70;
  localparam int unsigned T_AA_NS  = LOW_VOLTAGE ? 200 : 70;
  localparam int unsigned T_OA_NS  = LOW_VOLTAGE ? 100 : 35;
  localparam int unsigned T_WC_NS  = LOW_VOLTAGE ? 200 : 70;
  localparam int unsigned T_WP_NS  = LOW_VOLTAGE ? 140 : 55;
  localparam int unsigned T_DS_NS  = LOW_VOLTAGE ? 130 : 35;
  localparam int unsigned T_WOD_NS = LOW_VOLTAGE ? 60  : 30;
  localparam int unsigned T_OD_NS  = LOW_VOLTAGE ? 60  : 30;

  localparam int unsigned RC_C  = ns_to_cyc(T_RC_NS,  CLK_PERIOD_PS);
  localparam int unsigned AA_C  = ns_to_cyc(T_AA_NS,  CLK_PERIOD_PS);
  localparam int unsigned OA_C  = ns_to_cyc(T_OA_NS,  CLK_PERIOD_PS);
  localparam int unsigned WC_C  = ns_to_cyc(T_WC_NS,  CLK_PERIOD_PS);
  localparam int unsigned WP_C  = max_u(1, ns_to_cyc(T_WP_NS, CLK_PERIOD_PS));
  localparam int unsigned DS_C  = max_u(1, ns_to_cyc(T_DS_NS, CLK_PERIOD_PS));
  localparam int unsigned WOD_C = max_u(1, ns_to_cyc(T_WOD_NS, CLK_PERIOD_PS));
  localparam int unsigned OD_C  = ns_to_cyc(T_OD_NS,  CLK_PERIOD_PS);

  localparam int unsigned RD_CYC  = max_u(1, max_u(RC_C, max_u(AA_C, OA_C)));
  localparam int unsigned WR_CYC  = max_u(WC_C, max_u(WP_C, WOD_C + DS_C));
  localparam int unsigned REC_CYC = max_u(1, OD_C);
  localparam int unsigned MAX_CYC = max_u(RD_CYC, max_u(WR_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

  logic [CNT_W-1:0] elapsed;
  logic tmr_clr, accept, rd_sample, ready;

  sram_cyc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .elapsed_o (elapsed)
  );

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .WP_CYC  (WP_C),
    .WOD_CYC (WOD_C),
    .REC_CYC (REC_CYC),
    .CNT_W   (CNT_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .lowpwr_i    (lowpwr_i),
    .elapsed_i   (elapsed),
    .tmr_clr_o   (tmr_clr),
    .accept_o    (accept),
    .rd_sample_o (rd_sample),
    .ready_o     (ready),
    .done_o      (done_o),
    .ce_n_o      (ram_ce_no),
    .oe_n_o      (ram_oe_no),
    .we_n_o      (ram_we_no),
    .drv_o       (ram_dq_oe_o)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .rd_sample_i (rd_sample),
    .busy_i      (!ready),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ram_dq_i    (ram_dq_i),
    .ram_addr_o  (ram_addr_o),
    .ram_dq_o    (ram_dq_o),
    .rdata_o     (rdata_o)
  );

  assign ready_o = ready;

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  // expected cycle counts at 10 ns, fast 5 V timing
  localparam int RD_C  = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WR_C  = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP_C  = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int DS_C  = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WOD_C = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int REC_C = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OFF_C = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, lowpwr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [14:0] ram_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .wr_i        (wr),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .lowpwr_i    (lowpwr),
    .ready_o     (ready),
    .done_o      (done),
    .rdata_o     (rdata),
    .ram_addr_o  (ram_addr),
    .ram_ce_no   (ce_n),
    .ram_oe_no   (oe_n),
    .ram_we_no   (we_n),
    .ram_dq_o    (dq_o),
    .ram_dq_oe_o (dq_oe),
    .ram_dq_i    (dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0]  ram_m [int unsigned];
  logic [7:0]  exp_m [int unsigned];
  logic [7:0]  ram_val = '0;
  int          rd_cnt = 0, tail = 0, wcnt = 0, dcnt = 0;
  bit          prev_wlow = 1'b0, prev_rd = 1'b0;
  logic [14:0] waddr = '0, raddr = '0;
  logic [7:0]  wbuf = '0;
  logic        ram_on;

  assign ram_on = (!ce_n && !oe_n && we_n) || (tail > 0);
  assign dq_i   = ram_on ? ((rd_cnt >= RD_C) ? ram_val : ~ram_val)
                         : (dq_oe ? dq_o : 8'h00);

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_now, wlow;
      rd_now = !ce_n && !oe_n && we_n;
      wlow   = !ce_n && !we_n;
      if (!ce_n && !oe_n && !we_n) chk(1'b0, "R1", {ce_n, oe_n, we_n}, 3'b001);
      if (dq_oe && ram_on)         chk(1'b0, "R4", dq_oe, 0);
      rd_cnt = rd_now ? ((prev_rd && ram_addr == raddr) ? rd_cnt + 1 : 1) : 0;
      raddr  = ram_addr;
      ram_val = ram_m.exists(int'(ram_addr)) ? ram_m[int'(ram_addr)] : 8'h00;
      if (rd_now) tail = OFF_C;
      else if (tail > 0) tail--;
      if (wlow) begin
        if (!prev_wlow) waddr = ram_addr;
        else if (ram_addr != waddr) chk(1'b0, "R8", ram_addr, waddr);
        if (!oe_n) chk(1'b0, "R3", oe_n, 1);
        wcnt++;
        if (dq_oe) begin dcnt++; wbuf = dq_o; end
      end else if (prev_wlow) begin
        chk(wcnt >= WP_C, "R3", wcnt, WP_C);
        chk(dcnt >= DS_C, "R5", dcnt, DS_C);
        ram_m[int'(waddr)] = wbuf;
        wcnt = 0;
        dcnt = 0;
      end
      prev_wlow = wlow;
      prev_rd   = rd_now;
    end
  end

  // ---------------- one request, checked cycle by cycle ----------------
  task automatic do_op(input bit w, input logic [14:0] a, input logic [7:0] d, input bit poke);
    int len;
    len = w ? WR_C : RD_C;
    @(negedge clk);
    chk(ready == 1'b1, "R6", ready, 1);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; addr = 15'($urandom); wdata = 8'($urandom); wr = 1'($urandom);
    chk(ready == 1'b0, "R6", ready, 0);
    for (int j = 1; j <= len + REC_C; j++) begin
      @(negedge clk);
      if (j < len) begin
        chk(ce_n == 1'b0, w ? "R3" : "R1", ce_n, 0);
        if (w) begin
          chk(we_n == 1'b0 && oe_n == 1'b1, "R3", {oe_n, we_n}, 2'b10);
          chk(dq_oe == (j >= WOD_C), "R4", dq_oe, (j >= WOD_C));
          if (dq_oe) chk(dq_o == d, "R5", dq_o, d);
        end else begin
          chk(oe_n == 1'b0 && we_n == 1'b1 && dq_oe == 1'b0, "R1",
              {oe_n, we_n, dq_oe}, 3'b010);
        end
        chk(ram_addr == a, "R8", ram_addr, a);
      end
      if (j == len) begin
        chk(done == 1'b1, "R2", done, 1);
        chk(we_n && oe_n && !dq_oe, w ? "R4" : "R1", {we_n, oe_n, dq_oe}, 3'b110);
        if (!w) chk(rdata == exp_m[int'(a)], "R2", rdata, exp_m[int'(a)]);
      end else begin
        chk(done == 1'b0, "R2", done, 0);
      end
      chk(ready == (j >= len + REC_C), "R6", ready, (j >= len + REC_C));
      if (poke && j == 2) begin req = 1'b1; wr = 1'b1; addr = a ^ 15'h1; end
      if (poke && j == 3) req = 1'b0;
    end
    @(negedge clk);
    chk(we_n == 1'b1 && oe_n == 1'b1 && ready == 1'b1 && done == 1'b0, "R6",
        {we_n, oe_n, ready, done}, 4'b1110);
    if (w) exp_m[int'(a)] = d;
  endtask

  int unsigned wr_list[$];

  initial begin
    void'($urandom(32'd7219));
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R9", {ce_n, oe_n, we_n}, 3'b111);
    chk(!dq_oe && !done && ready, "R9", {dq_oe, done, ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n == 1'b0 && oe_n && we_n, "R7", {ce_n, oe_n, we_n}, 3'b011);

    // directed corners: address extremes, data extremes, back to back
    do_op(1'b1, 15'h0000, 8'hA5, 1'b0);
    do_op(1'b1, 15'h7FFF, 8'h5A, 1'b0);
    do_op(1'b1, 15'h4000, 8'hFF, 1'b0);
    do_op(1'b1, 15'h0001, 8'h00, 1'b0);
    wr_list.push_back(0); wr_list.push_back(32'h7FFF);
    wr_list.push_back(32'h4000); wr_list.push_back(1);
    do_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    do_op(1'b0, 15'h0000, 8'h00, 1'b0);
    do_op(1'b0, 15'h0001, 8'h00, 1'b0);

    // request while busy must be ignored (R6)
    do_op(1'b0, 15'h4000, 8'h00, 1'b1);
    do_op(1'b1, 15'h0000, 8'h3C, 1'b1);
    do_op(1'b0, 15'h0001, 8'h00, 1'b0);
    do_op(1'b0, 15'h0000, 8'h00, 1'b0);

    // low-power idle (R7)
    lowpwr = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n == 1'b1 && oe_n && we_n, "R7", {ce_n, oe_n, we_n}, 3'b111);
    do_op(1'b0, 15'h7FFF, 8'h00, 1'b0);
    chk(ce_n == 1'b1, "R7", ce_n, 1);
    do_op(1'b1, 15'h2222, 8'h81, 1'b0);
    wr_list.push_back(32'h2222);
    lowpwr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ce_n == 1'b0 && oe_n && we_n, "R7", {ce_n, oe_n, we_n}, 3'b011);

    // constrained random mix
    for (int i = 0; i < 80; i++) begin
      bit w;
      logic [14:0] a;
      w = ($urandom % 2) == 1;
      lowpwr = ($urandom % 4) == 0;
      if (w) begin
        a = 15'($urandom);
        do_op(1'b1, a, 8'($urandom), ($urandom % 5) == 0);
        wr_list.push_back(int'(a));
      end else begin
        a = 15'(wr_list[$urandom % wr_list.size()]);
        do_op(1'b0, a, 8'h00, ($urandom % 5) == 0);
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule